// File: doc/BRIEF.md
# GPIO Pad Bank with Trigger Capture

This block is a bank of general-purpose pads behind a small synchronous register port. Every pad has its own 16-byte register slot. The slot holds a configuration word, a spare second configuration word and a value word. The configuration word selects the pad function code, the pull settings, open-drain drive and the interrupt trigger. The value word holds two active-low enables, one for input and one for output, and the pad level.

Each pad input goes through a two-flop synchronizer. The block then compares the synchronized sample with the sample taken one cycle earlier to find edges, or looks at the sample alone for level triggers. A qualifying event sets one bit in a 32-bit status word. Each status word covers 32 pads. Software clears a status bit by writing a one to it. One combined interrupt line stays high while any status bit is set.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, every configuration word reads 0, every value word reads 3'b110 (both enables off, level 0), every status word reads 0, `irq` is low and no pad is driven.
- R2: The configuration word of pad p is at p*16 and the second configuration word is at p*16+4. Both read back all 32 written bits. The value word is at p*16+8 and keeps only bits 2:0. Slot offset 0xC, addresses between the last slot and 0x800, status words past the last one, and addresses that are not word-aligned all read 0. Read data appears in the cycle after `rd_en`.
- R3: With value bit 1 (output enable, active low) at 0 and open-drain off, the pad is driven (`pad_oe`=1) with `pad_out` equal to value bit 0. With value bit 1 at 1, the pad is not driven.
- R4: With configuration bit 31 set and the output enabled, `pad_out` is 0 and `pad_oe` is the inverse of value bit 0, so a level of 1 releases the pad.
- R5: With value bit 2 (input enable, active low) at 0, value bit 0 reads the pin as seen after the two-flop synchronizer. With bit 2 at 1, bit 0 reads the stored level.
- R6: Configuration bits 26:24 select the trigger. 3'b010 captures rising edges, 3'b100 captures falling edges and 3'b110 captures both. A captured event for pad p sets bit p mod 32 of the status word at 0x800 + (p/32)*4, three clock edges after the pin change.
- R7: Trigger code 3'b011 is an active-high level and 3'b101 is an active-low level. While the level is active, the status bit is set again on the cycle after a clear. Once the level is inactive, a clear holds.
- R8: Trigger code 3'b000 never sets a status bit. Configuration bit 27 (direct interrupt) keeps the pad out of the status words whatever its trigger code is.
- R9: A write to a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R10: When a capture event and a clear hit the same status bit in one cycle, the bit ends up set.
- R11: `irq` is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PADS | Pin levels from the pads |
| pad_out | output | NUM_PADS | Level driven onto each pad |
| pad_oe | output | NUM_PADS | Drive enable for each pad |
| irq | output | 1 | Combined interrupt |

## Verification
If a trigger code were decoded wrongly, the error would appear as a status bit that is set or clear at the wrong time. A status read issued three edges after the pin change exposes it, and so does `irq` in the same cycle. A wrong clear-versus-set priority appears as a one-cycle dip of `irq` right after the clearing write while a level stays active. The checks on pad drive and readback compare `pad_oe`, `pad_out` and the value word directly after each write. A slot decode error therefore shows up at the next read or the next clock.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  // configuration word bit positions (software decodes these)
  localparam int CFG_ODRAIN  = 31;
  localparam int CFG_DIRECT  = 27;
  localparam int CFG_FALL    = 26;
  localparam int CFG_RISE    = 25;
  localparam int CFG_LEVEL   = 24;
  // value word bit positions
  localparam int VAL_IN_N    = 2;
  localparam int VAL_OUT_N   = 1;
  localparam int VAL_LVL     = 0;
  // register selector inside a 16-byte slot
  typedef enum logic [1:0] {
    SEL_CFG0 = 2'd0,
    SEL_CFG1 = 2'd1,
    SEL_VAL  = 2'd2,
    SEL_NONE = 2'd3
  } slot_sel_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= raw;
      cur    <= stage1;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/gpio_pad_detect.sv
module gpio_pad_detect #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] sel_rise,
  input  logic [WIDTH-1:0] sel_fall,
  input  logic [WIDTH-1:0] sel_level,
  input  logic [WIDTH-1:0] direct,
  output logic [WIDTH-1:0] evt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    logic hit;
    always_comb begin
      if (sel_level[i])
        hit = (sel_rise[i] & cur[i]) | (sel_fall[i] & ~cur[i]);
      else
        hit = (sel_rise[i] & cur[i] & ~prev[i]) | (sel_fall[i] & ~cur[i] & prev[i]);
      evt[i] = hit & ~direct[i];
    end
  end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS  = 64,
  parameter int ADDR_W    = 12,
  parameter int STAT_BASE = 'h800
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq
);
  localparam int NWORDS   = (NUM_PADS + 31) / 32;
  localparam int SLOT_W   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int WIDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int PAD_SPAN = NUM_PADS * 16;
  localparam int WADDR_W  = ADDR_W - 2;

  // per-pad state
  logic [NUM_PADS-1:0][31:0] cfg0_q;
  logic [NUM_PADS-1:0][31:0] cfg1_q;
  logic [NUM_PADS-1:0]       in_n_q, out_n_q, lvl_q;
  logic [NUM_PADS-1:0]       status_q;
  logic [NUM_PADS-1:0]       cur, prev, evt, clr;
  logic [NUM_PADS-1:0]       sel_rise, sel_fall, sel_level, direct;

  // address decode
  logic               aligned, in_pads, in_stat;
  logic [SLOT_W-1:0]  slot;
  slot_sel_e          sel;
  logic [WADDR_W-1:0] stat_off;
  logic [WIDX_W-1:0]  widx;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    in_pads  = aligned && (addr < ADDR_W'(PAD_SPAN));
    slot     = addr[4 +: SLOT_W];
    sel      = slot_sel_e'(addr[3:2]);
    stat_off = addr[ADDR_W-1:2] - WADDR_W'(STAT_BASE / 4);
    in_stat  = aligned && (addr[ADDR_W-1:2] >= WADDR_W'(STAT_BASE / 4))
               && (stat_off < WADDR_W'(NWORDS));
    widx     = stat_off[WIDX_W-1:0];
  end

  gpio_pad_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk(clk), .rst(rst), .raw(pad_in), .cur(cur), .prev(prev)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    assign sel_rise[i]  = cfg0_q[i][CFG_RISE];
    assign sel_fall[i]  = cfg0_q[i][CFG_FALL];
    assign sel_level[i] = cfg0_q[i][CFG_LEVEL];
    assign direct[i]    = cfg0_q[i][CFG_DIRECT];
    assign clr[i]       = wr_en && in_stat && (widx == WIDX_W'(i / 32)) && wdata[i % 32];

    always_comb begin
      if (out_n_q[i]) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
      end else if (cfg0_q[i][CFG_ODRAIN]) begin
        pad_oe[i]  = ~lvl_q[i];
        pad_out[i] = 1'b0;
      end else begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = lvl_q[i];
      end
    end
  end

  gpio_pad_detect #(.WIDTH(NUM_PADS)) u_detect (
    .cur(cur), .prev(prev), .sel_rise(sel_rise), .sel_fall(sel_fall),
    .sel_level(sel_level), .direct(direct), .evt(evt)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0_q  <= '0;
      cfg1_q  <= '0;
      in_n_q  <= '1;
      out_n_q <= '1;
      lvl_q   <= '0;
    end else if (wr_en && in_pads) begin
      unique case (sel)
        SEL_CFG0: cfg0_q[slot] <= wdata;
        SEL_CFG1: cfg1_q[slot] <= wdata;
        SEL_VAL: begin
          in_n_q[slot]  <= wdata[VAL_IN_N];
          out_n_q[slot] <= wdata[VAL_OUT_N];
          lvl_q[slot]   <= wdata[VAL_LVL];
        end
        default: ;
      endcase
    end
  end

  // status: set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr) | evt;
  end

  assign irq = |status_q;

  // read path
  logic [NWORDS*32-1:0] stat_flat;
  logic [31:0]          rmux;

  always_comb begin
    stat_flat = '0;
    stat_flat[NUM_PADS-1:0] = status_q;
    rmux = '0;
    if (in_pads) begin
      unique case (sel)
        SEL_CFG0: rmux = cfg0_q[slot];
        SEL_CFG1: rmux = cfg1_q[slot];
        SEL_VAL:  rmux = {29'd0, in_n_q[slot], out_n_q[slot],
                          in_n_q[slot] ? lvl_q[slot] : cur[slot]};
        default:  rmux = '0;
      endcase
    end else if (in_stat) begin
      rmux = stat_flat[widx*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int NUM_PADS = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_PADS-1:0]       status_q,
  input logic [NUM_PADS-1:0]       evt,
  input logic [NUM_PADS-1:0]       clr,
  input logic [NUM_PADS-1:0][31:0] cfg0_q,
  input logic [NUM_PADS-1:0]       pad_oe,
  input logic [NUM_PADS-1:0]       pad_out,
  input logic                      irq
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_q == '0 && !irq));

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
    assert_no_trig_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg0_q[i][26:24]) == 3'b000 && !$past(status_q[i])) |-> !status_q[i]);
    assert_direct_block_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg0_q[i][27]) && !$past(status_q[i])) |-> !status_q[i]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      $past(evt[i]) |-> status_q[i]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
      $past(clr[i] && !evt[i]) |-> !status_q[i]);
    assert_odrain_low_R4: assert property (@(posedge clk) disable iff (rst)
      (cfg0_q[i][31] && pad_oe[i]) |-> !pad_out[i]);
  end
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk(clk), .rst(rst), .status_q(status_q), .evt(evt), .clr(clr),
  .cfg0_q(cfg0_q), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
);

// File: tb/gpio_pad_bank_bench.sv
module gpio_pad_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;
  int            vectors = 0, fails = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_bank u_gpio_pad_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [11:0] slot(int p, int off);
    return 12'(p * 16 + off);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(slot(7, 0), d);  chk("R1 cfg0 after reset", d, 32'h0);
    rd(slot(7, 8), d);  chk("R1 value after reset", d, 32'h6);
    rd(12'h800, d);     chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    chk("R1 no pad driven", {31'd0, |pad_oe}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(slot(63, 4), 32'hDEADBEEF);
    rd(slot(63, 4), d); chk("R2 cfg1 readback", d, 32'hDEADBEEF);
    wr(slot(62, 0), 32'h1234_0685);
    rd(slot(62, 0), d); chk("R2 cfg0 readback", d, 32'h1234_0685);
    wr(slot(62, 0), 32'h0);
    wr(slot(63, 8), 32'hFFFF_FFFE);
    rd(slot(63, 8), d); chk("R2 value keeps bits 2:0", d, 32'h6);
    rd(slot(63, 12), d); chk("R2 slot offset C reads 0", d, 32'h0);
    rd(12'h500, d);     chk("R2 gap reads 0", d, 32'h0);
    rd(12'h808, d);     chk("R2 status word past end reads 0", d, 32'h0);
    rd(slot(63, 5), d); chk("R2 unaligned reads 0", d, 32'h0);
  endtask

  task automatic t_drive();
    wr(slot(20, 8), 32'h1);
    chk("R3 driven high oe", {31'd0, pad_oe[20]}, 32'h1);
    chk("R3 driven high out", {31'd0, pad_out[20]}, 32'h1);
    wr(slot(20, 8), 32'h0);
    chk("R3 driven low out", {31'd0, pad_out[20]}, 32'h0);
    wr(slot(20, 8), 32'h7);
    chk("R3 output disabled", {31'd0, pad_oe[20]}, 32'h0);
    wr(slot(20, 0), 32'h8000_0000);
    wr(slot(20, 8), 32'h0);
    chk("R4 open-drain pulls low oe", {31'd0, pad_oe[20]}, 32'h1);
    chk("R4 open-drain pulls low out", {31'd0, pad_out[20]}, 32'h0);
    wr(slot(20, 8), 32'h1);
    chk("R4 open-drain releases", {31'd0, pad_oe[20]}, 32'h0);
    wr(slot(20, 0), 32'h0);
    wr(slot(20, 8), 32'h6);
  endtask

  task automatic t_input();
    logic [31:0] d;
    wr(slot(21, 8), 32'h2);
    pad_in[21] = 1'b1;
    cyc(3);
    rd(slot(21, 8), d); chk("R5 input readback high", d, 32'h3);
    wr(slot(21, 8), 32'h6);
    rd(slot(21, 8), d); chk("R5 input disabled reads stored", d, 32'h6);
    pad_in[21] = 1'b0;
    wr(slot(21, 8), 32'h2);
    cyc(3);
    rd(slot(21, 8), d); chk("R5 input readback low", d, 32'h2);
    wr(slot(21, 8), 32'h6);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(slot(37, 0), 32'h0200_0000);
    pad_in[37] = 1'b1;
    cyc(3);
    rd(12'h804, d); chk("R6 rising sets word1 bit5", d, 32'h20);
    chk("R11 irq with status", {31'd0, irq}, 32'h1);
    wr(12'h804, 32'h20);
    rd(12'h804, d); chk("R9 clear rising", d, 32'h0);
    chk("R11 irq drops", {31'd0, irq}, 32'h0);
    pad_in[37] = 1'b0;
    cyc(3);
    rd(12'h804, d); chk("R6 rising ignores fall", d, 32'h0);
    wr(slot(37, 0), 32'h0);
    pad_in[3] = 1'b1;
    cyc(3);
    wr(slot(3, 0), 32'h0400_0000);
    cyc(2);
    rd(12'h800, d); chk("R6 falling idle", d, 32'h0);
    pad_in[3] = 1'b0;
    cyc(3);
    rd(12'h800, d); chk("R6 falling sets bit3", d, 32'h8);
    wr(12'h800, 32'hFFFF_FFFF);
    wr(slot(3, 0), 32'h0);
    wr(slot(5, 0), 32'h0600_0000);
    pad_in[5] = 1'b1;
    cyc(3);
    rd(12'h800, d); chk("R6 both edges rise", d, 32'h20);
    wr(12'h800, 32'h20);
    pad_in[5] = 1'b0;
    cyc(3);
    rd(12'h800, d); chk("R6 both edges fall", d, 32'h20);
    wr(12'h800, 32'h0);
    rd(12'h800, d); chk("R9 zero write keeps bit", d, 32'h20);
    wr(12'h800, 32'hFFFF_FFFF);
    wr(slot(5, 0), 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    wr(slot(10, 0), 32'h0300_0000);
    cyc(2);
    rd(12'h800, d); chk("R7 high level idle", d, 32'h0);
    pad_in[10] = 1'b1;
    cyc(3);
    rd(12'h800, d); chk("R7 high level sets", d, 32'h400);
    wr(12'h800, 32'h400);
    chk("R10 set wins over clear", {31'd0, irq}, 32'h1);
    rd(12'h800, d); chk("R7 level re-sets after clear", d, 32'h400);
    pad_in[10] = 1'b0;
    cyc(3);
    wr(12'h800, 32'h400);
    rd(12'h800, d); chk("R7 clear holds when inactive", d, 32'h0);
    wr(slot(10, 0), 32'h0);
    wr(slot(11, 0), 32'h0500_0000);
    cyc(2);
    rd(12'h800, d); chk("R7 low level sets", d, 32'h800);
    pad_in[11] = 1'b1;
    cyc(3);
    wr(12'h800, 32'h800);
    rd(12'h800, d); chk("R7 low level inactive clears", d, 32'h0);
    wr(slot(11, 0), 32'h0);
  endtask

  task automatic t_blocked();
    logic [31:0] d;
    wr(slot(13, 0), 32'h0A00_0000);
    pad_in[12] = 1'b1;
    pad_in[13] = 1'b1;
    cyc(3);
    pad_in[12] = 1'b0;
    pad_in[13] = 1'b0;
    cyc(3);
    rd(12'h800, d); chk("R8 no trigger and direct pads silent", d, 32'h0);
    chk("R8 irq stays low", {31'd0, irq}, 32'h0);
    wr(slot(13, 0), 32'h0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_regs();
    t_drive();
    t_input();
    t_edges();
    t_levels();
    t_blocked();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule